// File: doc/BRIEF.md
# Shared-RAM Register Mailbox Responder

This block is the device-side agent of a mailbox through which a host reaches peripheral registers that it cannot address directly. The host sees only a two-location port: one location selects a byte of a small shared RAM, the other reads or writes that selected byte. To touch a hidden register, the host places the register number and, when writing, the data into agreed RAM bytes, then stores a request code into a mode byte. The responder notices the request, drives a single access on its local register bus, deposits read data back into the RAM and finally clears the mode byte. The host reads that cleared value as its acknowledgement.

While no request is pending, the responder keeps a live copy of the peripheral's interrupt identification byte, its receive FIFO status byte and the receive FIFO contents in the RAM. It refreshes them one byte per idle cycle in a fixed round. The RAM has a single write port. When the host and the responder want to write in the same cycle, the host wins and the responder waits.

Top module: `mailbox_responder`

## Requirements
- R1: A host write at port offset 0 loads the RAM byte index, and a read at offset 0 returns that index. Accesses at offset 1 never change the index, so it does not auto-increment.
- R2: Offset 1 reads and writes the RAM byte selected by the index. Indices at or past the RAM depth (0x20 plus the FIFO copy length) read as 0x00, and writes to them are dropped. Every RAM byte and the index are 0x00 after reset.
- R3: When the mode byte at 0x1A holds 0x01 and no request is in progress, the responder raises `regWrEn` for exactly one cycle, with `regAddr` taken from byte 0x1B and `regWrData` taken from byte 0x1C. It then writes 0x00 to the mode byte.
- R4: When the mode byte holds 0x02, the responder raises `regRdEn` for exactly one cycle with `regAddr` taken from byte 0x1B. It captures `regRdData` in the following cycle and writes the captured value into byte 0x1C. Only after that does it write 0x00 to the mode byte.
- R5: Any nonzero mode value other than 0x01 and 0x02 is written back to 0x00 and produces no register bus access.
- R6: While the mode byte is 0x00, each granted idle cycle refreshes one mirror byte, in the order 0x1E, 0x1F, then 0x20 up to 0x20 plus the copy length minus one, and then wraps. Byte 0x1E copies `irqIdent`, byte 0x1F copies `rxStatus`, and byte 0x20+k copies FIFO entry k, which is bits [8k+7:8k] of `rxFifoFlat`.
- R7: A host write at offset 1 takes the RAM write port in its cycle. Any responder write due in that cycle is held back and retried, and the host's data remains in the RAM.
- R8: `regWrEn` and `regRdEn` are never high together, and each request produces at most one bus strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host write strobe for the two-location port |
| hostAddr | input | 1 | Host port offset: 0 is the index, 1 is the data |
| hostWrData | input | 8 | Host write data |
| hostRdData | output | 8 | Index (offset 0) or the selected RAM byte (offset 1) |
| regWrEn | output | 1 | Local register bus write strobe |
| regRdEn | output | 1 | Local register bus read strobe |
| regAddr | output | 8 | Local register number |
| regWrData | output | 8 | Local register write data |
| regRdData | input | 8 | Read data, valid the cycle after `regRdEn` |
| irqIdent | input | 8 | Interrupt identification byte to mirror |
| rxStatus | input | 8 | Receive FIFO status byte to mirror |
| rxFifoFlat | input | 8*RX_COPY | Receive FIFO entries to mirror, entry k in bits [8k+7:8k] |

## Verification
The bench builds the block with RX_COPY set to 4. This gives a 36-byte RAM and a mirror round of six slots, so the round wraps within a few idle cycles, and the first out-of-range index (0x24) sits right after the last mirror byte. At this size a stall caused by host writes during a read request, and the retry that follows it, fit inside short directed sequences. These are compared every cycle against a behavioural model.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int BYTE_W = 8;

  // shared RAM layout the host depends on
  localparam logic [7:0] MODE_LOC = 8'h1A;
  localparam logic [7:0] TGT_LOC  = 8'h1B;
  localparam logic [7:0] VAL_LOC  = 8'h1C;
  localparam logic [7:0] IRQ_LOC  = 8'h1E;
  localparam logic [7:0] STAT_LOC = 8'h1F;
  localparam logic [7:0] FIFO_LOC = 8'h20;

  // request codes in the mode byte
  localparam logic [7:0] REQ_IDLE  = 8'h00;
  localparam logic [7:0] REQ_WRITE = 8'h01;
  localparam logic [7:0] REQ_READ  = 8'h02;

  typedef enum logic [1:0] {
    ST_SCAN,
    ST_CAPTURE,
    ST_STORE,
    ST_ACK
  } respState_t;

  typedef struct packed {
    logic clearMode;
    logic storeValue;
    logic storeMirror;
    logic captureRead;
    logic busWrite;
    logic busRead;
  } respStrobe_t;
endpackage

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int RX_COPY = 8,
  parameter int PTR_W   = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        hostWrEn,
  input  logic                        hostAddr,
  input  logic [BYTE_W-1:0]           hostWrData,
  output logic [BYTE_W-1:0]           hostRdData,
  output logic [BYTE_W-1:0]           hostIdx,
  input  respStrobe_t                 strobe,
  input  logic [PTR_W-1:0]            mirrorSel,
  output logic                        respGrant,
  output logic [BYTE_W-1:0]           modeByte,
  output logic [BYTE_W-1:0]           regAddr,
  output logic [BYTE_W-1:0]           regWrData,
  input  logic [BYTE_W-1:0]           regRdData,
  input  logic [BYTE_W-1:0]           irqIdent,
  input  logic [BYTE_W-1:0]           rxStatus,
  input  logic [RX_COPY*BYTE_W-1:0]   rxFifoFlat
);
  localparam int DEPTH = int'(FIFO_LOC) + RX_COPY;
  localparam int AW    = $clog2(DEPTH);

  logic [BYTE_W-1:0] ram [DEPTH];
  logic [BYTE_W-1:0] idxQ;
  logic [BYTE_W-1:0] holdQ;
  logic              hostDataWr;
  logic              idxInRange;
  logic              wrEn;
  logic [AW-1:0]     wrAddr;
  logic [BYTE_W-1:0] wrData;
  logic [BYTE_W-1:0] mirrorLoc;
  logic [BYTE_W-1:0] mirrorData;

  assign hostDataWr = hostWrEn && hostAddr;
  assign idxInRange = int'(idxQ) < DEPTH;
  assign respGrant  = !hostDataWr;

  // mirror slot decode: 0 -> irq byte, 1 -> status byte, 2.. -> FIFO copy
  always_comb begin
    mirrorLoc  = IRQ_LOC;
    mirrorData = irqIdent;
    if (mirrorSel == PTR_W'(1)) begin
      mirrorLoc  = STAT_LOC;
      mirrorData = rxStatus;
    end
    for (int k = 0; k < RX_COPY; k++) begin
      if (mirrorSel == PTR_W'(k + 2)) begin
        mirrorLoc  = FIFO_LOC + BYTE_W'(k);
        mirrorData = rxFifoFlat[k*BYTE_W +: BYTE_W];
      end
    end
  end

  // single RAM write port, host first
  always_comb begin
    wrEn   = 1'b0;
    wrAddr = '0;
    wrData = '0;
    if (hostDataWr) begin
      wrEn   = idxInRange;
      wrAddr = AW'(idxQ);
      wrData = hostWrData;
    end else if (strobe.clearMode) begin
      wrEn   = 1'b1;
      wrAddr = AW'(MODE_LOC);
      wrData = REQ_IDLE;
    end else if (strobe.storeValue) begin
      wrEn   = 1'b1;
      wrAddr = AW'(VAL_LOC);
      wrData = holdQ;
    end else if (strobe.storeMirror) begin
      wrEn   = 1'b1;
      wrAddr = AW'(mirrorLoc);
      wrData = mirrorData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) ram[i] <= '0;
    end else if (wrEn) begin
      ram[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ  <= '0;
      holdQ <= '0;
    end else begin
      if (hostWrEn && !hostAddr) idxQ <= hostWrData;
      if (strobe.captureRead) holdQ <= regRdData;
    end
  end

  assign hostRdData = hostAddr ? (idxInRange ? ram[AW'(idxQ)] : '0) : idxQ;
  assign hostIdx    = idxQ;
  assign modeByte   = ram[AW'(MODE_LOC)];
  assign regAddr    = ram[AW'(TGT_LOC)];
  assign regWrData  = ram[AW'(VAL_LOC)];
endmodule

// File: rtl/mbox_control.sv
module mbox_control
  import mbox_pkg::*;
#(
  parameter int MIRROR_N = 10,
  parameter int PTR_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] modeByte,
  input  logic              respGrant,
  output respStrobe_t       strobe,
  output logic [PTR_W-1:0]  mirrorSel
);
  respState_t       stateQ, stateD;
  logic [PTR_W-1:0] ptrQ;
  logic             mirrorStep;

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_SCAN: begin
        if (modeByte == REQ_WRITE) begin
          strobe.busWrite = 1'b1;
          stateD          = ST_ACK;
        end else if (modeByte == REQ_READ) begin
          strobe.busRead = 1'b1;
          stateD         = ST_CAPTURE;
        end else if (modeByte != REQ_IDLE) begin
          strobe.clearMode = 1'b1;
        end else begin
          strobe.storeMirror = 1'b1;
        end
      end
      ST_CAPTURE: begin
        strobe.captureRead = 1'b1;
        stateD             = ST_STORE;
      end
      ST_STORE: begin
        strobe.storeValue = 1'b1;
        if (respGrant) stateD = ST_ACK;
      end
      ST_ACK: begin
        strobe.clearMode = 1'b1;
        if (respGrant) stateD = ST_SCAN;
      end
      default: stateD = ST_SCAN;
    endcase
  end

  assign mirrorStep = (stateQ == ST_SCAN) && (modeByte == REQ_IDLE) && respGrant;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_SCAN;
      ptrQ   <= '0;
    end else begin
      stateQ <= stateD;
      if (mirrorStep) ptrQ <= (ptrQ == PTR_W'(MIRROR_N - 1)) ? '0 : ptrQ + PTR_W'(1);
    end
  end

  assign mirrorSel = ptrQ;
endmodule

// File: rtl/mailbox_responder.sv
module mailbox_responder
  import mbox_pkg::*;
#(
  parameter int RX_COPY = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      hostWrEn,
  input  logic                      hostAddr,
  input  logic [7:0]                hostWrData,
  output logic [7:0]                hostRdData,
  output logic                      regWrEn,
  output logic                      regRdEn,
  output logic [7:0]                regAddr,
  output logic [7:0]                regWrData,
  input  logic [7:0]                regRdData,
  input  logic [7:0]                irqIdent,
  input  logic [7:0]                rxStatus,
  input  logic [RX_COPY*8-1:0]      rxFifoFlat
);
  localparam int MIRROR_N = RX_COPY + 2;
  localparam int PTR_W    = $clog2(MIRROR_N);

  respStrobe_t       strobe;
  logic [PTR_W-1:0]  mirrorSel;
  logic              respGrant;
  logic [BYTE_W-1:0] modeByte;
  logic [BYTE_W-1:0] hostIdx;

  mbox_control #(.MIRROR_N(MIRROR_N), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeByte(modeByte), .respGrant(respGrant),
    .strobe(strobe), .mirrorSel(mirrorSel)
  );

  mbox_datapath #(.RX_COPY(RX_COPY), .PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .hostIdx(hostIdx),
    .strobe(strobe), .mirrorSel(mirrorSel), .respGrant(respGrant),
    .modeByte(modeByte), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqIdent(irqIdent), .rxStatus(rxStatus),
    .rxFifoFlat(rxFifoFlat)
  );

  assign regWrEn = strobe.busWrite;
  assign regRdEn = strobe.busRead;
endmodule

// File: rtl/mailbox_responder_chk.sv
module mailbox_responder_chk #(
  parameter int DEPTH = 40
) (
  input logic       clk,
  input logic       rstN,
  input logic       hostWrEn,
  input logic       hostAddr,
  input logic [7:0] hostWrData,
  input logic [7:0] hostRdData,
  input logic [7:0] hostIdx,
  input logic       regWrEn,
  input logic       regRdEn
);
  // R8: never both bus strobes
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));

  // R3: a write request strobes once
  p_write_once_r3: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (!regWrEn && !regRdEn));

  // R4: a read request strobes once
  p_read_once_r4: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> (!regRdEn && !regWrEn));

  // R1: index holds without an offset-0 write
  p_index_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!hostAddr && !hostWrEn) |=> (hostAddr || $stable(hostRdData)));

  // R7: host data write survives any responder write in that cycle
  p_host_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr && (int'(hostIdx) < DEPTH))
      |=> (!hostAddr || hostRdData == $past(hostWrData)));
endmodule

bind mailbox_responder mailbox_responder_chk #(.DEPTH(32 + RX_COPY)) u_chk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
  .hostWrData(hostWrData), .hostRdData(hostRdData), .hostIdx(hostIdx),
  .regWrEn(regWrEn), .regRdEn(regRdEn)
);

// File: tb/mailbox_responder_bench.sv
module mailbox_responder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RX_COPY    = 4;
  localparam int DEPTH      = 32 + RX_COPY;
  localparam int NSLOT      = RX_COPY + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0;
  logic hostAddr = 1'b0;
  logic [7:0] hostWrData = '0;
  logic [7:0] hostRdData;
  logic regWrEn, regRdEn;
  logic [7:0] regAddr, regWrData;
  logic [7:0] regRdData = '0;
  logic [7:0] irqIdent = '0;
  logic [7:0] rxStatus = '0;
  logic [RX_COPY*8-1:0] rxFifoFlat = '0;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // behavioural model state
  int mem [256];
  int mIdx = 0;
  int phase = 0;   // 0 scan, 2 capture, 3 store, 4 ack
  int slot = 0;
  int held = 0;
  int periph [16];
  int rdNext = 0;
  int lastRd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mailbox_responder #(.RX_COPY(RX_COPY)) u_mailbox_responder (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqIdent(irqIdent), .rxStatus(rxStatus),
    .rxFifoFlat(rxFifoFlat)
  );

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int slotLoc(int s);
    if (s == 0) return 'h1E;
    if (s == 1) return 'h1F;
    return 'h20 + s - 2;
  endfunction

  function automatic int slotVal(int s);
    if (s == 0) return int'(irqIdent);
    if (s == 1) return int'(rxStatus);
    return int'(rxFifoFlat[(s-2)*8 +: 8]);
  endfunction

  // one clock: compare at the negedge, advance the model, move to next negedge
  task automatic cyc();
    int mode, expRd, nIdx;
    bit expWr, expRdEn, busy, rwEn;
    int rwAddr, rwData;
    #1;
    mode    = mem['h1A];
    expWr   = (phase == 0) && (mode == 1);
    expRdEn = (phase == 0) && (mode == 2);
    expRd   = hostAddr ? ((mIdx < DEPTH) ? mem[mIdx] : 0) : mIdx;
    lastRd  = int'(hostRdData);
    check(hostAddr ? "R2 host data read" : "R1 host index read", int'(hostRdData), expRd);
    check("R3 regWrEn", int'(regWrEn), int'(expWr));
    check("R4 regRdEn", int'(regRdEn), int'(expRdEn));
    if (expWr) begin
      check("R3 regAddr", int'(regAddr), mem['h1B]);
      check("R3 regWrData", int'(regWrData), mem['h1C]);
      periph[mem['h1B] % 16] = mem['h1C];
    end
    if (expRdEn) begin
      check("R4 regAddr", int'(regAddr), mem['h1B]);
      rdNext = periph[mem['h1B] % 16];
    end
    busy = hostWrEn && hostAddr;
    rwEn = 0; rwAddr = 0; rwData = 0;
    nIdx = mIdx;
    case (phase)
      0: begin
        if (mode == 1) phase = 4;
        else if (mode == 2) phase = 2;
        else if (mode != 0) begin rwEn = !busy; rwAddr = 'h1A; rwData = 0; end
        else if (!busy) begin
          rwEn = 1; rwAddr = slotLoc(slot); rwData = slotVal(slot);
          slot = (slot + 1) % NSLOT;
        end
      end
      2: begin held = int'(regRdData); phase = 3; end
      3: if (!busy) begin rwEn = 1; rwAddr = 'h1C; rwData = held; phase = 4; end
      default: if (!busy) begin rwEn = 1; rwAddr = 'h1A; rwData = 0; phase = 0; end
    endcase
    if (hostWrEn && !hostAddr) nIdx = int'(hostWrData);
    if (busy && mIdx < DEPTH) mem[mIdx] = int'(hostWrData);
    if (rwEn) mem[rwAddr] = rwData;
    mIdx = nIdx;
    @(posedge clk);
    @(negedge clk);
    regRdData = 8'(rdNext);
  endtask

  task automatic hostWrite(bit a, int d);
    hostWrEn = 1; hostAddr = a; hostWrData = 8'(d);
    cyc();
    hostWrEn = 0;
  endtask

  task automatic putByte(int loc, int d);
    hostWrite(0, loc);
    hostWrite(1, d);
  endtask

  // select a byte and read it at offset 1 (returned in lastRd)
  task automatic getByte(int loc);
    hostWrite(0, loc);
    hostAddr = 1;
    cyc();
  endtask

  task automatic waitAck();
    hostWrite(0, 'h1A);
    hostAddr = 1;
    for (int n = 0; n < 20; n++) begin
      cyc();
      if (lastRd == 0) break;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 0;
    for (int i = 0; i < 16; i++) periph[i] = 'h30 + i;
    #(CLK_PERIOD*20000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R8 reset state: no strobes, index zero
    check("R8 reset regWrEn", int'(regWrEn), 0);
    check("R8 reset regRdEn", int'(regRdEn), 0);
    check("R1 reset index", int'(hostRdData), 0);
    rstN = 1;
    @(negedge clk);
    hostAddr = 1;
    cyc();
    check("R2 reset byte zero", lastRd, 0);

    // R1 index load and no auto-increment
    hostWrite(0, 'h05);
    hostAddr = 0; cyc();
    check("R1 index readback", lastRd, 'h05);
    hostWrite(1, 'h6C);
    hostAddr = 1; cyc(); cyc();
    hostAddr = 0; cyc();
    check("R1 no auto-increment", lastRd, 'h05);

    // R2 byte access and out-of-range index
    getByte('h05);
    check("R2 byte write/read", lastRd, 'h6C);
    putByte('h24, 'h99);
    getByte('h24);
    check("R2 out-of-range reads zero", lastRd, 0);

    // R3 write request
    putByte('h1B, 'h07);
    putByte('h1C, 'hA5);
    putByte('h1A, 'h01);
    waitAck();
    check("R3 mode acknowledged", lastRd, 0);
    check("R3 peripheral written", periph[7], 'hA5);

    // R4 read request
    putByte('h1B, 'h09);
    putByte('h1A, 'h02);
    waitAck();
    check("R4 mode acknowledged", lastRd, 0);
    getByte('h1C);
    check("R4 value returned", lastRd, 'h39);

    // R7 host writes stall the store of read data
    putByte('h1B, 'h0B);
    putByte('h1A, 'h02);
    hostWrite(0, 'h05);
    for (int n = 0; n < 5; n++) hostWrite(1, 'h50 + n);
    getByte('h05);
    check("R7 host data kept", lastRd, 'h54);
    waitAck();
    getByte('h1C);
    check("R7 stalled store completes", lastRd, 'h3B);

    // R5 unknown mode code cleared without bus access
    putByte('h1A, 'h07);
    hostAddr = 1; cyc(); cyc();
    check("R5 mode cleared", lastRd, 0);
    check("R5 peripheral untouched", periph[7], 'hA5);

    // R6 mirror round
    irqIdent = 8'h06;
    rxStatus = 8'h83;
    rxFifoFlat = {8'h44, 8'h33, 8'h22, 8'h11};
    for (int n = 0; n < 2*NSLOT; n++) cyc();
    getByte('h1E); check("R6 irq mirror", lastRd, 'h06);
    getByte('h1F); check("R6 status mirror", lastRd, 'h83);
    getByte('h20); check("R6 fifo entry 0", lastRd, 'h11);
    getByte('h23); check("R6 fifo last entry", lastRd, 'h44);
    rxStatus = 8'h12;
    for (int n = 0; n < 2*NSLOT; n++) cyc();
    getByte('h1F); check("R6 mirror refreshed", lastRd, 'h12);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule